// File: doc/BRIEF.md
# Subset Integer Instruction Execute Unit

This block executes one 32-bit integer instruction per cycle from a small instruction subset. An instruction word offered with a valid strobe is split into its fields. Two operands are read from a 32-entry by 32-bit register file and the result is computed in the same cycle. The result is written to the destination register on the clock edge that accepts the instruction. The supported register-register operations are add, subtract, AND, OR, NOR, and logical shifts left and right by a constant amount. The immediate forms are add, AND and OR.

Word loads and stores form their address from a base register and a signed 16-bit offset. They then run a request/acknowledge transaction on a word-wide data port. While that transaction is open, the instruction port is held not-ready. Words outside the subset, and memory accesses to an address that is not a multiple of four, raise a one-cycle flag and change no state. Program flow is not part of this block: there is no branching, no jumping and no program counter.

Top module: `int_exec_unit`

## Requirements
- R1: After reset every register reads as zero, `instr_ready` is 1, and `mem_req`, `illegal_o` and `misalign_o` are 0.
- R2: Opcode 0 with funct 32 (add) writes rs+rt to rd, and with funct 34 (sub) writes rs-rt to rd. Both wrap modulo 2^32 without any trap. An instruction may read the same register it writes; it then uses the old value.
- R3: Opcode 0 with funct 36 writes rs AND rt to rd, funct 37 writes rs OR rt, and funct 39 writes NOT(rs OR rt). A NOR with register 0 as one operand therefore yields the bitwise NOT of the other operand.
- R4: Opcode 0 with funct 0 shifts rt left by shamt (bits [10:6]) into rd, and funct 2 shifts it right. In both cases the vacated bits fill with zeros and bits shifted past either end are lost.
- R5: Opcode 8 writes rs plus the sign-extended immediate [15:0] to rt. Opcode 12 writes rs AND the zero-extended immediate, and opcode 13 writes rs OR the zero-extended immediate.
- R6: Register 0 always reads as zero, and writes to it have no effect.
- R7: Opcode 35 (load) computes the address rs + sign-extended imm. In the cycle after acceptance it raises `mem_req` with `mem_we`=0. The request and its address stay stable, and `instr_ready` stays 0, until `mem_ack`. On the clock edge where `mem_ack` is sampled, rt is loaded with `mem_rdata`.
- R8: Opcode 43 (store) computes the same address form and raises `mem_req` with `mem_we`=1 and `mem_wdata` equal to rt, using the same hold-until-acknowledge protocol.
- R9: A load or store whose address has nonzero bits [1:0] raises no request and writes no register. Instead it pulses `misalign_o` for the one cycle after acceptance.
- R10: Any other opcode, or opcode 0 with any other funct, pulses `illegal_o` for the one cycle after acceptance and changes no register and no memory. A word presented with `instr_valid` low has no effect.
- R11: The word 0x01098022 executes as a subtract with rs=8, rt=9 and rd=16. The word 0x2210005F executes as an add-immediate with rs=16, rt=16 and immediate 95.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is offered this cycle |
| instr_word | input | 32 | Instruction word |
| instr_ready | output | 1 | Unit can accept an instruction this cycle |
| illegal_o | output | 1 | One-cycle pulse: last accepted word was outside the subset |
| misalign_o | output | 1 | One-cycle pulse: last accepted load/store had an unaligned address |
| mem_req | output | 1 | Data port request, held until acknowledged |
| mem_we | output | 1 | 1 for a store, 0 for a load |
| mem_addr | output | 32 | Byte address of the word access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, sampled with mem_ack |
| mem_ack | input | 1 | Completes the open request on this clock edge |

## Verification
Two things can coincide in one cycle. The register file is read for an operand, and the same register is written with that instruction's result. The bench provokes this with an add and a shift whose destination is also their source, for example adding a register to itself. It judges the outcome by reading the register out through a store: the value must be derived from the old contents and then replaced by the new one. A second case is the load write-back on the acknowledge edge. The stall in the cycles before it is checked at the ports, and the instruction that follows must see the loaded value.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

   // Fixed by the instruction encoding
   localparam int INSTR_W = 32;
   localparam int FIELD_W = 5;

   typedef enum logic [3:0] {
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOR, OP_SLL, OP_SRL,
      OP_ADDI, OP_ANDI, OP_ORI, OP_LW, OP_SW, OP_BAD
   } iexu_op_e;

   localparam logic [5:0] OPC_REG  = 6'd0;
   localparam logic [5:0] OPC_ADDI = 6'd8;
   localparam logic [5:0] OPC_ANDI = 6'd12;
   localparam logic [5:0] OPC_ORI  = 6'd13;
   localparam logic [5:0] OPC_LW   = 6'd35;
   localparam logic [5:0] OPC_SW   = 6'd43;

   localparam logic [5:0] FN_SLL = 6'd0;
   localparam logic [5:0] FN_SRL = 6'd2;
   localparam logic [5:0] FN_ADD = 6'd32;
   localparam logic [5:0] FN_SUB = 6'd34;
   localparam logic [5:0] FN_AND = 6'd36;
   localparam logic [5:0] FN_OR  = 6'd37;
   localparam logic [5:0] FN_NOR = 6'd39;

endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
   import iexu_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int RIDX_W = 5,
   parameter int SH_W   = 5
) (
   input  logic [INSTR_W-1:0] instr_i,
   output iexu_op_e           op_o,
   output logic [RIDX_W-1:0]  rs_o,
   output logic [RIDX_W-1:0]  rt_o,
   output logic [RIDX_W-1:0]  dst_o,
   output logic [SH_W-1:0]    shamt_o,
   output logic [XLEN-1:0]    imm_o,
   output logic               wr_en_o,
   output logic               is_mem_o,
   output logic               is_store_o
);

   localparam int IMM_W = 16;

   if (RIDX_W != FIELD_W) begin : g_bad_ridx
      $error("iexu_decode: register index width must equal the 5-bit field");
   end
   if (SH_W != FIELD_W) begin : g_bad_sh
      $error("iexu_decode: shift amount width must equal the 5-bit field");
   end
   if (XLEN < IMM_W) begin : g_bad_xlen
      $error("iexu_decode: XLEN narrower than the immediate");
   end

   logic [5:0]       opcode;
   logic [5:0]       funct;
   logic [IMM_W-1:0] imm16;
   logic [XLEN-1:0]  imm_sext;
   logic [XLEN-1:0]  imm_zext;
   logic             zext_sel;

   assign opcode   = instr_i[31:26];
   assign funct    = instr_i[5:0];
   assign imm16    = instr_i[15:0];
   assign rs_o     = instr_i[25:21];
   assign rt_o     = instr_i[20:16];
   assign shamt_o  = instr_i[10:6];
   assign imm_sext = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
   assign imm_zext = {{(XLEN-IMM_W){1'b0}}, imm16};
   assign imm_o    = zext_sel ? imm_zext : imm_sext;

   always_comb begin
      op_o       = OP_BAD;
      dst_o      = instr_i[20:16];
      wr_en_o    = 1'b0;
      is_mem_o   = 1'b0;
      is_store_o = 1'b0;
      zext_sel   = 1'b0;
      case (opcode)
         OPC_REG: begin
            dst_o = instr_i[15:11];
            case (funct)
               FN_ADD:  op_o = OP_ADD;
               FN_SUB:  op_o = OP_SUB;
               FN_AND:  op_o = OP_AND;
               FN_OR:   op_o = OP_OR;
               FN_NOR:  op_o = OP_NOR;
               FN_SLL:  op_o = OP_SLL;
               FN_SRL:  op_o = OP_SRL;
               default: op_o = OP_BAD;
            endcase
            wr_en_o = (op_o != OP_BAD);
         end
         OPC_ADDI: begin
            op_o    = OP_ADDI;
            wr_en_o = 1'b1;
         end
         OPC_ANDI: begin
            op_o     = OP_ANDI;
            wr_en_o  = 1'b1;
            zext_sel = 1'b1;
         end
         OPC_ORI: begin
            op_o     = OP_ORI;
            wr_en_o  = 1'b1;
            zext_sel = 1'b1;
         end
         OPC_LW: begin
            op_o     = OP_LW;
            is_mem_o = 1'b1;
         end
         OPC_SW: begin
            op_o       = OP_SW;
            is_mem_o   = 1'b1;
            is_store_o = 1'b1;
         end
         default: op_o = OP_BAD;
      endcase
   end

endmodule

// File: rtl/iexu_regfile.sv
module iexu_regfile #(
   parameter int XLEN    = 32,
   parameter int NREGS   = 32,
   parameter bit ZERO_R0 = 1'b1,
   localparam int RIDX_W = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [RIDX_W-1:0] waddr_i,
   input  logic [XLEN-1:0]   wdata_i,
   input  logic [RIDX_W-1:0] raddr_a_i,
   output logic [XLEN-1:0]   rdata_a_o,
   input  logic [RIDX_W-1:0] raddr_b_i,
   output logic [XLEN-1:0]   rdata_b_o
);

   if (NREGS < 2 || (1 << RIDX_W) != NREGS) begin : g_bad_depth
      $error("iexu_regfile: NREGS must be a power of two of at least 2");
   end

   logic [NREGS-1:0][XLEN-1:0] bank;

   for (genvar i = 0; i < NREGS; i++) begin : g_ent
      if (i == 0 && ZERO_R0) begin : g_const
         // Entry 0 has no storage at all: reads are always zero
         assign bank[i] = '0;
      end else begin : g_flop
         logic [XLEN-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (we_i && waddr_i == RIDX_W'(i)) begin
               q <= wdata_i;
            end
         end
         assign bank[i] = q;
      end
   end

   assign rdata_a_o = bank[raddr_a_i];
   assign rdata_b_o = bank[raddr_b_i];

   if (ZERO_R0) begin : g_r0_chk
      assert_r0_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (raddr_a_i == '0) |-> (rdata_a_o == '0));
   end

endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
   import iexu_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int SHIFT_IMPL = 1,
   localparam int SH_W      = $clog2(XLEN)
) (
   input  iexu_op_e          op_i,
   input  logic [XLEN-1:0]   a_i,
   input  logic [XLEN-1:0]   b_i,
   input  logic [XLEN-1:0]   imm_i,
   input  logic [SH_W-1:0]   shamt_i,
   output logic [XLEN-1:0]   result_o
);

   if (SHIFT_IMPL != 0 && SHIFT_IMPL != 1) begin : g_bad_impl
      $error("iexu_alu: SHIFT_IMPL must be 0 (operator) or 1 (staged)");
   end

   logic [XLEN-1:0] opnd;
   logic [XLEN-1:0] shl;
   logic [XLEN-1:0] shr;

   // Immediate forms take the extended immediate in place of rt
   assign opnd = (op_i == OP_ADDI || op_i == OP_ANDI || op_i == OP_ORI) ? imm_i : b_i;

   if (SHIFT_IMPL == 0) begin : g_shift_op
      assign shl = b_i << shamt_i;
      assign shr = b_i >> shamt_i;
   end else begin : g_shift_staged
      // One mux level per shamt bit, shift by 2**k at level k
      logic [SH_W:0][XLEN-1:0] lft;
      logic [SH_W:0][XLEN-1:0] rgt;
      assign lft[0] = b_i;
      assign rgt[0] = b_i;
      for (genvar k = 0; k < SH_W; k++) begin : g_stage
         assign lft[k+1] = shamt_i[k] ? (lft[k] << (2**k)) : lft[k];
         assign rgt[k+1] = shamt_i[k] ? (rgt[k] >> (2**k)) : rgt[k];
      end
      assign shl = lft[SH_W];
      assign shr = rgt[SH_W];
   end

   always_comb begin
      case (op_i)
         OP_ADD, OP_ADDI: result_o = a_i + opnd;
         OP_SUB:          result_o = a_i - opnd;
         OP_AND, OP_ANDI: result_o = a_i & opnd;
         OP_OR,  OP_ORI:  result_o = a_i | opnd;
         OP_NOR:          result_o = ~(a_i | opnd);
         OP_SLL:          result_o = shl;
         OP_SRL:          result_o = shr;
         default:         result_o = '0;
      endcase
   end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import iexu_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NREGS      = 32,
   parameter bit ZERO_R0    = 1'b1,
   parameter int SHIFT_IMPL = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr_word,
   output logic               instr_ready,
   output logic               illegal_o,
   output logic               misalign_o,
   output logic               mem_req,
   output logic               mem_we,
   output logic [XLEN-1:0]    mem_addr,
   output logic [XLEN-1:0]    mem_wdata,
   input  logic [XLEN-1:0]    mem_rdata,
   input  logic               mem_ack
);

   localparam int RIDX_W     = $clog2(NREGS);
   localparam int SH_W       = $clog2(XLEN);
   localparam int ALIGN_BITS = $clog2(XLEN / 8);

   if (XLEN != 32) begin : g_bad_xlen
      $error("int_exec_unit: the shift field and word alignment need XLEN of 32");
   end
   if (NREGS != (1 << FIELD_W)) begin : g_bad_nregs
      $error("int_exec_unit: the 5-bit register fields need 32 registers");
   end

   // Decode
   iexu_op_e          dec_op;
   logic [RIDX_W-1:0] dec_rs;
   logic [RIDX_W-1:0] dec_rt;
   logic [RIDX_W-1:0] dec_dst;
   logic [SH_W-1:0]   dec_shamt;
   logic [XLEN-1:0]   dec_imm;
   logic              dec_wr_en;
   logic              dec_is_mem;
   logic              dec_is_store;

   iexu_decode #(.XLEN(XLEN), .RIDX_W(RIDX_W), .SH_W(SH_W)) u_dec (
      .instr_i    (instr_word),
      .op_o       (dec_op),
      .rs_o       (dec_rs),
      .rt_o       (dec_rt),
      .dst_o      (dec_dst),
      .shamt_o    (dec_shamt),
      .imm_o      (dec_imm),
      .wr_en_o    (dec_wr_en),
      .is_mem_o   (dec_is_mem),
      .is_store_o (dec_is_store)
   );

   // Register file
   logic              rf_we;
   logic [RIDX_W-1:0] rf_waddr;
   logic [XLEN-1:0]   rf_wdata;
   logic [XLEN-1:0]   rs_val;
   logic [XLEN-1:0]   rt_val;

   iexu_regfile #(.XLEN(XLEN), .NREGS(NREGS), .ZERO_R0(ZERO_R0)) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (rf_we),
      .waddr_i   (rf_waddr),
      .wdata_i   (rf_wdata),
      .raddr_a_i (dec_rs),
      .rdata_a_o (rs_val),
      .raddr_b_i (dec_rt),
      .rdata_b_o (rt_val)
   );

   // Compute
   logic [XLEN-1:0] alu_res;

   iexu_alu #(.XLEN(XLEN), .SHIFT_IMPL(SHIFT_IMPL)) u_alu (
      .op_i     (dec_op),
      .a_i      (rs_val),
      .b_i      (rt_val),
      .imm_i    (dec_imm),
      .shamt_i  (dec_shamt),
      .result_o (alu_res)
   );

   // Pending memory transaction
   logic              busy_q;
   logic              we_q;
   logic [XLEN-1:0]   addr_q;
   logic [XLEN-1:0]   wdata_q;
   logic [RIDX_W-1:0] dst_q;
   logic              illegal_q;
   logic              misalign_q;

   logic            accept;
   logic [XLEN-1:0] agu;
   logic            unaligned;
   logic            mem_go;
   logic            mem_bad;

   assign instr_ready = !busy_q;
   assign accept      = instr_valid && instr_ready;
   assign agu         = rs_val + dec_imm;
   assign unaligned   = |agu[ALIGN_BITS-1:0];
   assign mem_go      = accept && dec_is_mem && !unaligned;
   assign mem_bad     = accept && dec_is_mem && unaligned;

   // One write port: a load completes only while the port is stalled,
   // so it never competes with a compute result
   always_comb begin
      rf_we    = accept && dec_wr_en;
      rf_waddr = dec_dst;
      rf_wdata = alu_res;
      if (busy_q) begin
         rf_we    = mem_ack && !we_q;
         rf_waddr = dst_q;
         rf_wdata = mem_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         we_q       <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
         dst_q      <= '0;
         illegal_q  <= 1'b0;
         misalign_q <= 1'b0;
      end else begin
         illegal_q  <= accept && (dec_op == OP_BAD);
         misalign_q <= mem_bad;
         if (busy_q) begin
            if (mem_ack) begin
               busy_q <= 1'b0;
            end
         end else if (mem_go) begin
            busy_q  <= 1'b1;
            we_q    <= dec_is_store;
            addr_q  <= agu;
            wdata_q <= rt_val;
            dst_q   <= dec_dst;
         end
      end
   end

   assign mem_req    = busy_q;
   assign mem_we     = we_q;
   assign mem_addr   = addr_q;
   assign mem_wdata  = wdata_q;
   assign illegal_o  = illegal_q;
   assign misalign_o = misalign_q;

   assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   assert_busy_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !instr_ready);

   assert_req_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[ALIGN_BITS-1:0] == '0));

   assert_misalign_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_o |-> !mem_req);

   assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({illegal_o, misalign_o}));

   assert_illegal_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dec_op == OP_BAD) |-> !rf_we);

   assert_sll_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dec_op == OP_SLL) |-> ((alu_res & ~({XLEN{1'b1}} << dec_shamt)) == '0));

endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int MEM_LAT    = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr_word = '0;
   logic        instr_ready;
   logic        illegal_o;
   logic        misalign_o;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   int n_vec = 0;
   int n_bad = 0;

   logic [31:0] mem [64];
   logic [31:0] last_addr;
   logic [31:0] last_wdata;
   logic        last_we;
   logic        last_req;
   logic        last_illegal;
   logic        last_misalign;
   logic        stall_ok;
   logic [31:0] rv;

   always #(CLK_PERIOD/2) clk = ~clk;

   int_exec_unit u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr_word  (instr_word),
      .instr_ready (instr_ready),
      .illegal_o   (illegal_o),
      .misalign_o  (misalign_o),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata),
      .mem_ack     (mem_ack)
   );

   function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                         input int sh, input int fn);
      return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
   endfunction

   function automatic logic [31:0] enc_i(input int op, input int rs, input int rt,
                                         input logic [15:0] imm);
      return {op[5:0], rs[4:0], rt[4:0], imm};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Offer one word, then serve a memory request if one appears
   task automatic exec(input logic [31:0] w);
      @(negedge clk);
      instr_word  = w;
      instr_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      instr_valid   = 1'b0;
      last_illegal  = illegal_o;
      last_misalign = misalign_o;
      last_req      = mem_req;
      if (mem_req) begin
         last_addr  = mem_addr;
         last_we    = mem_we;
         last_wdata = mem_wdata;
         stall_ok   = !instr_ready;
         for (int i = 0; i < MEM_LAT; i++) begin
            @(negedge clk);
            if (instr_ready || !mem_req || mem_addr !== last_addr) stall_ok = 1'b0;
         end
         mem_rdata = mem[last_addr[7:2]];
         if (last_we) mem[last_addr[7:2]] = last_wdata;
         mem_ack = 1'b1;
         @(posedge clk);
         @(negedge clk);
         mem_ack   = 1'b0;
         mem_rdata = '0;
      end
   endtask

   // Store register r to address 0 and capture the data on the port
   task automatic read_reg(input int r, output logic [31:0] v);
      exec(enc_i(43, 0, r, 16'h0000));
      v = last_wdata;
   endtask

   task automatic set_reg(input int r, input logic [31:0] v);
      exec(enc_i(13, 0, r, v[31:16]));
      exec(enc_r(0, r, r, 16, 0));
      exec(enc_i(13, r, r, v[15:0]));
   endtask

   task automatic t_reset();
      check("R1 instr_ready", {31'b0, instr_ready}, 32'd1);
      check("R1 mem_req", {31'b0, mem_req}, 32'd0);
      check("R1 flags", {30'b0, illegal_o, misalign_o}, 32'd0);
      read_reg(5, rv);  check("R1 r5", rv, 32'h0);
      read_reg(31, rv); check("R1 r31", rv, 32'h0);
   endtask

   task automatic t_examples();
      set_reg(8, 32'd100);
      set_reg(9, 32'd30);
      exec(32'h01098022);
      read_reg(16, rv); check("R11 sub word", rv, 32'd70);
      exec(32'h2210005F);
      read_reg(16, rv); check("R11 addi word", rv, 32'd165);
   endtask

   task automatic t_arith();
      set_reg(1, 32'hFFFF_FFFF);
      set_reg(2, 32'd2);
      exec(enc_r(1, 2, 3, 0, 32));
      read_reg(3, rv); check("R2 add wrap", rv, 32'd1);
      exec(enc_r(2, 1, 4, 0, 34));
      read_reg(4, rv); check("R2 sub", rv, 32'd3);
      exec(enc_r(0, 2, 5, 0, 34));
      read_reg(5, rv); check("R2 sub below zero", rv, 32'hFFFF_FFFE);
   endtask

   task automatic t_logic();
      set_reg(10, 32'hF0F0_1234);
      set_reg(11, 32'h0FF0_FF00);
      exec(enc_r(10, 11, 12, 0, 36));
      read_reg(12, rv); check("R3 and", rv, 32'h00F0_1200);
      exec(enc_r(10, 11, 13, 0, 37));
      read_reg(13, rv); check("R3 or", rv, 32'hFFF0_FF34);
      exec(enc_r(10, 11, 14, 0, 39));
      read_reg(14, rv); check("R3 nor", rv, 32'h000F_00CB);
      exec(enc_r(10, 0, 14, 0, 39));
      read_reg(14, rv); check("R3 nor as not", rv, 32'h0F0F_EDCB);
   endtask

   task automatic t_shift();
      set_reg(20, 32'd9);
      exec(enc_r(0, 20, 21, 4, 0));
      read_reg(21, rv); check("R4 sll 4", rv, 32'd144);
      exec(enc_r(0, 20, 22, 28, 0));
      read_reg(22, rv); check("R4 sll bits lost", rv, 32'h9000_0000);
      set_reg(23, 32'h8000_0001);
      exec(enc_r(0, 23, 24, 31, 2));
      read_reg(24, rv); check("R4 srl 31", rv, 32'h1);
      exec(enc_r(0, 23, 25, 1, 2));
      read_reg(25, rv); check("R4 srl zero fill", rv, 32'h4000_0000);
      exec(enc_r(0, 23, 25, 0, 2));
      read_reg(25, rv); check("R4 srl 0", rv, 32'h8000_0001);
      exec(enc_r(0, 23, 26, 1, 0));
      read_reg(26, rv); check("R4 sll 1", rv, 32'h2);
   endtask

   task automatic t_imm();
      exec(enc_i(8, 0, 27, 16'hFFFF));
      read_reg(27, rv); check("R5 addi sext", rv, 32'hFFFF_FFFF);
      exec(enc_i(8, 27, 28, 16'h0005));
      read_reg(28, rv); check("R5 addi wrap", rv, 32'd4);
      exec(enc_i(12, 27, 29, 16'h8001));
      read_reg(29, rv); check("R5 andi zext", rv, 32'h0000_8001);
      exec(enc_i(13, 0, 30, 16'h8000));
      read_reg(30, rv); check("R5 ori zext", rv, 32'h0000_8000);
      exec(enc_i(8, 30, 30, 16'h8000));
      read_reg(30, rv); check("R5 addi negative", rv, 32'h0);
   endtask

   task automatic t_zero();
      exec(enc_i(8, 0, 0, 16'h1234));
      read_reg(0, rv); check("R6 addi to r0", rv, 32'h0);
      exec(enc_r(27, 27, 0, 0, 32));
      read_reg(0, rv); check("R6 add to r0", rv, 32'h0);
      exec(enc_r(0, 0, 1, 0, 39));
      read_reg(1, rv); check("R6 r0 operand", rv, 32'hFFFF_FFFF);
   endtask

   task automatic t_load();
      mem[10] = 32'hCAFE_F00D;
      mem[14] = 32'h1357_9BDF;
      set_reg(6, 32'h20);
      exec(enc_i(35, 6, 7, 16'h0008));
      check("R7 req", {31'b0, last_req}, 32'd1);
      check("R7 we", {31'b0, last_we}, 32'd0);
      check("R7 addr", last_addr, 32'h28);
      check("R7 stall", {31'b0, stall_ok}, 32'd1);
      read_reg(7, rv); check("R7 loaded", rv, 32'hCAFE_F00D);
      set_reg(6, 32'h40);
      exec(enc_i(35, 6, 9, 16'hFFF8));
      check("R7 neg offset addr", last_addr, 32'h38);
      read_reg(9, rv); check("R7 neg offset data", rv, 32'h1357_9BDF);
   endtask

   task automatic t_store();
      set_reg(12, 32'hA5A5_5A5A);
      exec(enc_i(43, 6, 12, 16'h0004));
      check("R8 we", {31'b0, last_we}, 32'd1);
      check("R8 addr", last_addr, 32'h44);
      check("R8 wdata", last_wdata, 32'hA5A5_5A5A);
      check("R8 stall", {31'b0, stall_ok}, 32'd1);
      exec(enc_i(35, 6, 13, 16'h0004));
      read_reg(13, rv); check("R8 round trip", rv, 32'hA5A5_5A5A);
   endtask

   task automatic t_misalign();
      mem[16] = 32'hDEAD_0016;
      set_reg(15, 32'h1111_1111);
      exec(enc_i(35, 6, 15, 16'h0002));
      check("R9 lw no req", {31'b0, last_req}, 32'd0);
      check("R9 lw flags", {30'b0, last_misalign, last_illegal}, 32'd2);
      read_reg(15, rv); check("R9 lw dest kept", rv, 32'h1111_1111);
      exec(enc_i(43, 6, 15, 16'h0001));
      check("R9 sw no req", {31'b0, last_req}, 32'd0);
      check("R9 sw flag", {31'b0, last_misalign}, 32'd1);
      exec(enc_i(35, 6, 15, 16'h0000));
      read_reg(15, rv); check("R9 memory kept", rv, 32'hDEAD_0016);
      check("R9 flag cleared", {31'b0, misalign_o}, 32'd0);
   endtask

   task automatic t_illegal();
      set_reg(17, 32'h2222_2222);
      exec(enc_i(63, 0, 17, 16'h0001));
      check("R10 bad opcode flag", {30'b0, last_illegal, last_misalign}, 32'd2);
      check("R10 bad opcode no req", {31'b0, last_req}, 32'd0);
      exec(enc_r(1, 2, 17, 0, 1));
      check("R10 bad funct flag", {31'b0, last_illegal}, 32'd1);
      exec(enc_i(2, 0, 17, 16'h0001));
      check("R10 jump opcode flag", {31'b0, last_illegal}, 32'd1);
      read_reg(17, rv); check("R10 dest kept", rv, 32'h2222_2222);
      check("R10 flag cleared", {31'b0, illegal_o}, 32'd0);
      @(negedge clk);
      instr_word  = enc_i(8, 0, 17, 16'h0005);
      instr_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      read_reg(17, rv); check("R10 valid low ignored", rv, 32'h2222_2222);
   endtask

   task automatic t_same_reg();
      set_reg(3, 32'h4000_0001);
      exec(enc_r(3, 3, 3, 0, 32));
      read_reg(3, rv); check("R2 read and write same reg", rv, 32'h8000_0002);
      exec(enc_r(0, 3, 3, 1, 0));
      read_reg(3, rv); check("R4 shift in place", rv, 32'h4);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_examples();
      t_arith();
      t_logic();
      t_shift();
      t_imm();
      t_zero();
      t_load();
      t_store();
      t_misalign();
      t_illegal();
      t_same_reg();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule